// File: doc/BRIEF.md
# Accumulator Processor ALU

This block is the combinational arithmetic and logic unit of an 8-bit accumulator processor. Each cycle the surrounding datapath presents an operation code, the accumulator, the two index registers, an operand byte and the current condition flags (negative, overflow, zero, carry). The unit returns the new result byte, the new flag nibble, and a strobe saying whether the result is meant to be written back. The carry, overflow, zero and negative rules follow the classic 8-bit accumulator machine. This includes subtraction with an inverted-borrow carry, a bit test that copies operand bits into the flags, and a combined AND-then-subtract operation whose result goes to the X index register.

Decimal arithmetic, the register file, instruction sequencing and memory access are not part of the block. The caller chooses the destination: the accumulator, X, or the memory byte for shift, rotate, increment and decrement. The unit holds no state. Outputs follow inputs within the same cycle.

Top module: `acc_alu`

## Requirements
- R1: Flags are packed as bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C on both the flag input and the flag output. Opcode 0 (add with carry) returns low8(A + operand + C). C becomes bit 8 of the 9-bit sum. V is set when A and the operand have equal sign bits and the result's sign bit differs from A's.
- R2: Opcode 1 (subtract with carry) returns low8(A − operand − (1 − C)). C is set when no borrow occurred. V is set when A and the operand have different sign bits and A and the result also have different sign bits.
- R3: Opcodes 2, 3 and 4 compare the operand against A, X and Y respectively. Z and N come from the low byte of the difference. C is set when the register value is greater than or equal to the operand, and V is unchanged. result_o equals a_i and store_o is 0.
- R4: Opcode 8 (bit test) sets Z when (A AND operand) is zero, copies operand bit 7 into N and operand bit 6 into V, and leaves C unchanged. result_o equals a_i and store_o is 0.
- R5: Opcode 11 (rotate left) returns the operand shifted left with the old C in bit 0, and moves operand bit 7 into C. Opcode 12 (rotate right) returns the operand shifted right with the old C in bit 7, and moves operand bit 0 into C. V is unchanged for both.
- R6: Opcode 9 (shift left) moves operand bit 7 into C and fills bit 0 with zero. Opcode 10 (logical shift right) moves operand bit 0 into C, fills bit 7 with zero and therefore always yields N = 0. V is unchanged for both.
- R7: Opcode 15 (AND-subtract) returns low8((A AND X) − operand) for writing into X. Z, N and C follow the compare rules, and V is unchanged.
- R8: Opcodes 13 (increment operand) and 14 (decrement operand) wrap modulo 256. They update only Z and N, so C and V equal their inputs.
- R9: For every opcode that writes a result, store_o is 1, Z is set exactly when result_o is zero, and N equals bit 7 of result_o.
- R10: Opcodes 5 (AND), 6 (OR), 7 (XOR) and 16 (operand pass-through) return A AND operand, A OR operand, A XOR operand and the operand respectively. They change only Z and N.
- R11: Opcodes 17 to 31 are undefined. result_o equals a_i, flags_o equals flags_i and store_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index register value |
| y_i | input | 8 | Y index register value |
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 4 | Incoming flags {N,V,Z,C} |
| result_o | output | 8 | Result byte |
| flags_o | output | 4 | Updated flags {N,V,Z,C} |
| store_o | output | 1 | Result is to be written back |

## Verification
The bench builds the unit with its default 8-bit data width. At that width every one of the 256 operand values can be swept for each shift, rotate, increment and decrement, with both carry-in values. The same holds for the boundary values 0x00, 0x7F, 0x80 and 0xFF combined with each other for add, subtract and the compares. Random vectors over all 32 opcode values then reach the signed-overflow cases, the AND-subtract and the undefined codes. A reference function in the bench is written with plain integer arithmetic and checks each vector.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADC  = 5'd0,
        OP_SBC  = 5'd1,
        OP_CMPA = 5'd2,
        OP_CMPX = 5'd3,
        OP_CMPY = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_BIT  = 5'd8,
        OP_SHL  = 5'd9,
        OP_SHR  = 5'd10,
        OP_ROL  = 5'd11,
        OP_ROR  = 5'd12,
        OP_INC  = 5'd13,
        OP_DEC  = 5'd14,
        OP_ANDS = 5'd15,
        OP_PASS = 5'd16
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_ARITH,
        CL_CMP,
        CL_LOGIC,
        CL_BIT,
        CL_SHIFT,
        CL_STEP,
        CL_NONE
    } op_class_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    function automatic op_class_e classify(input logic [4:0] op);
        case (op)
            OP_ADC, OP_SBC:                   return CL_ARITH;
            OP_CMPA, OP_CMPX, OP_CMPY, OP_ANDS: return CL_CMP;
            OP_AND, OP_OR, OP_XOR, OP_PASS:   return CL_LOGIC;
            OP_BIT:                           return CL_BIT;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR:   return CL_SHIFT;
            OP_INC, OP_DEC:                   return CL_STEP;
            default:                          return CL_NONE;
        endcase
    endfunction

    function automatic logic is_compare(input logic [4:0] op);
        return (op == OP_CMPA) || (op == OP_CMPX) || (op == OP_CMPY);
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           vout
);
    localparam int MSB = W - 1;

    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    logic         cadd;
    logic [W:0]   sum;

    // Left operand choice: accumulator, either index, or A AND X
    always_comb begin
        case (op)
            OP_CMPX: lhs = x;
            OP_CMPY: lhs = y;
            OP_ANDS: lhs = a & x;
            default: lhs = a;
        endcase
    end

    // Subtraction is addition of the complement; carry-in supplies the +1
    assign rhs  = (op == OP_ADC) ? b : ~b;
    assign cadd = (op == OP_ADC || op == OP_SBC) ? cin : 1'b1;
    assign sum  = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cadd};

    assign res  = sum[W-1:0];
    assign cout = sum[W];
    assign vout = ~(lhs[MSB] ^ rhs[MSB]) & (lhs[MSB] ^ sum[MSB]);

    always_comb begin
        if (!$isunknown({op, a, b, cin})) begin
            if (op == OP_SBC && cin)
                p_sub_no_borrow_r2: assert (cout == (a >= b))
                    else $error("subtract carry disagrees with magnitude");
            if (op == OP_CMPA)
                p_cmp_carry_r3: assert (cout == (a >= b))
                    else $error("compare carry disagrees with magnitude");
        end
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           bit_z,
    output logic           bit_n,
    output logic           bit_v
);
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] xor_v;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_lane
            assign and_v[i] = a[i] & b[i];
            assign or_v[i]  = a[i] | b[i];
            assign xor_v[i] = a[i] ^ b[i];
        end
    endgenerate

    always_comb begin
        case (op)
            OP_AND:  res = and_v;
            OP_OR:   res = or_v;
            OP_XOR:  res = xor_v;
            default: res = b;
        endcase
    end

    // Bit test: zero from the mask, sign and overflow taken from the operand
    assign bit_z = ~|and_v;
    assign bit_n = b[W-1];
    assign bit_v = b[W-2];

    always_comb begin
        if (!$isunknown({a, b}))
            p_bit_mask_r4: assert (bit_z == ((a & b) == '0))
                else $error("bit-test zero flag disagrees with mask");
    end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        res  = b;
        cout = cin;
        case (op)
            OP_SHL: begin
                res  = {b[W-2:0], 1'b0};
                cout = b[W-1];
            end
            OP_SHR: begin
                res  = {1'b0, b[W-1:1]};
                cout = b[0];
            end
            OP_ROL: begin
                res  = {b[W-2:0], cin};
                cout = b[W-1];
            end
            OP_ROR: begin
                res  = {cin, b[W-1:1]};
                cout = b[0];
            end
            OP_INC:  res = b + ONE;
            OP_DEC:  res = b - ONE;
            default: res = b;
        endcase
    end

    always_comb begin
        if (!$isunknown({op, b, cin})) begin
            if (op == OP_SHR)
                p_shr_sign_clear_r6: assert (res[W-1] == 1'b0)
                    else $error("logical right shift left sign bit set");
            if (op == OP_ROR)
                p_ror_carry_in_r5: assert (res[W-1] == cin && cout == b[0])
                    else $error("rotate right carry path wrong");
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [4:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] opnd_i,
    input  logic [3:0]   flags_i,
    output logic [W-1:0] result_o,
    output logic [3:0]   flags_o,
    output logic         store_o
);
    alu_op_e   op;
    op_class_e cls;
    flags_t    fin;
    flags_t    fout;

    logic [W-1:0] add_res;
    logic         add_c;
    logic         add_v;
    logic [W-1:0] log_res;
    logic         bit_z;
    logic         bit_n;
    logic         bit_v;
    logic [W-1:0] sh_res;
    logic         sh_c;

    assign op  = alu_op_e'(op_i);
    assign cls = classify(op_i);
    assign fin = flags_t'(flags_i);

    acc_alu_adder #(.W(W)) u_adder (
        .op   (op),
        .a    (a_i),
        .x    (x_i),
        .y    (y_i),
        .b    (opnd_i),
        .cin  (fin.c),
        .res  (add_res),
        .cout (add_c),
        .vout (add_v)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .op    (op),
        .a     (a_i),
        .b     (opnd_i),
        .res   (log_res),
        .bit_z (bit_z),
        .bit_n (bit_n),
        .bit_v (bit_v)
    );

    acc_alu_shift #(.W(W)) u_shift (
        .op   (op),
        .b    (opnd_i),
        .cin  (fin.c),
        .res  (sh_res),
        .cout (sh_c)
    );

    always_comb begin
        result_o = a_i;
        fout     = fin;
        store_o  = 1'b0;
        case (cls)
            CL_ARITH: begin
                result_o = add_res;
                store_o  = 1'b1;
                fout.c   = add_c;
                fout.v   = add_v;
                fout.z   = ~|add_res;
                fout.n   = add_res[W-1];
            end
            CL_CMP: begin
                // AND-subtract keeps its difference; plain compares discard it
                if (op == OP_ANDS) begin
                    result_o = add_res;
                    store_o  = 1'b1;
                end
                fout.c = add_c;
                fout.z = ~|add_res;
                fout.n = add_res[W-1];
            end
            CL_LOGIC: begin
                result_o = log_res;
                store_o  = 1'b1;
                fout.z   = ~|log_res;
                fout.n   = log_res[W-1];
            end
            CL_BIT: begin
                fout.z = bit_z;
                fout.n = bit_n;
                fout.v = bit_v;
            end
            CL_SHIFT: begin
                result_o = sh_res;
                store_o  = 1'b1;
                fout.c   = sh_c;
                fout.z   = ~|sh_res;
                fout.n   = sh_res[W-1];
            end
            CL_STEP: begin
                result_o = sh_res;
                store_o  = 1'b1;
                fout.z   = ~|sh_res;
                fout.n   = sh_res[W-1];
            end
            default: begin
                result_o = a_i;
                fout     = fin;
                store_o  = 1'b0;
            end
        endcase
    end

    assign flags_o = fout;

    always_comb begin
        if (!$isunknown({op_i, a_i, x_i, y_i, opnd_i, flags_i})) begin
            if (op_i == 5'd13 || op_i == 5'd14)
                p_step_cv_hold_r8: assert (flags_o[0] == flags_i[0] && flags_o[2] == flags_i[2])
                    else $error("increment/decrement touched C or V");
            if (is_compare(op_i))
                p_cmp_v_hold_r3: assert (flags_o[2] == flags_i[2] && !store_o && result_o == a_i)
                    else $error("compare changed V or requested a store");
            if (store_o)
                p_store_zn_r9: assert (flags_o[1] == (result_o == '0) && flags_o[3] == result_o[W-1])
                    else $error("Z/N disagree with stored result");
            if (op_i > 5'd16)
                p_undef_inert_r11: assert (flags_o == flags_i && !store_o)
                    else $error("undefined opcode had an effect");
            if (op_i == 5'd8)
                p_bit_copy_r4: assert (flags_o[3] == opnd_i[W-1] && flags_o[2] == opnd_i[W-2])
                    else $error("bit test did not copy operand bits");
        end
    end

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i;
    logic [7:0] a_i, x_i, y_i, opnd_i;
    logic [3:0] flags_i;
    logic [7:0] result_o;
    logic [3:0] flags_o;
    logic       store_o;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    acc_alu #(.W(8)) dut_i (
        .op_i(op_i), .a_i(a_i), .x_i(x_i), .y_i(y_i), .opnd_i(opnd_i),
        .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o), .store_o(store_o)
    );

    function automatic string req_of(input int op);
        case (op)
            0:  return "R1";
            1:  return "R2";
            2, 3, 4: return "R3";
            5, 6, 7, 16: return "R10";
            8:  return "R4";
            9, 10: return "R6";
            11, 12: return "R5";
            13, 14: return "R8";
            15: return "R7";
            default: return "R11";
        endcase
    endfunction

    // Reference model: {store, flags[3:0], result[7:0]}
    function automatic logic [12:0] model(input int op, input int a, input int x,
                                          input int y, input int b, input logic [3:0] f);
        int s, res, lhs;
        logic n, v, z, c, st;
        n = f[3]; v = f[2]; z = f[1]; c = f[0];
        res = a; st = 1'b0;
        case (op)
            0: begin
                s = a + b + int'(c); res = s & 255; c = s > 255;
                v = (((a ^ b) & 8'h80) == 0) && (((a ^ res) & 8'h80) != 0);
                st = 1;
            end
            1: begin
                s = a - b - (1 - int'(c)); res = s & 255; c = s >= 0;
                v = (((a ^ b) & 8'h80) != 0) && (((a ^ res) & 8'h80) != 0);
                st = 1;
            end
            2, 3, 4, 15: begin
                lhs = (op == 2) ? a : (op == 3) ? x : (op == 4) ? y : (a & x);
                s = lhs - b; c = s >= 0;
                z = (s & 255) == 0; n = ((s & 255) >> 7) != 0;
                if (op == 15) begin res = s & 255; st = 1; end
            end
            5:  begin res = a & b; st = 1; end
            6:  begin res = a | b; st = 1; end
            7:  begin res = a ^ b; st = 1; end
            16: begin res = b; st = 1; end
            8: begin
                z = (a & b) == 0; n = b[7]; v = b[6];
            end
            9:  begin c = b[7]; res = (b << 1) & 255; st = 1; end
            10: begin c = b[0]; res = b >> 1; st = 1; end
            11: begin res = ((b << 1) | int'(c)) & 255; c = b[7]; st = 1; end
            12: begin res = (b >> 1) | (int'(c) << 7); c = b[0]; st = 1; end
            13: begin res = (b + 1) & 255; st = 1; end
            14: begin res = (b + 255) & 255; st = 1; end
            default: ;
        endcase
        if (st) begin
            // R9: Z and N follow the stored byte
            z = (res == 0); n = ((res >> 7) & 1) != 0;
        end
        return {st, n, v, z, c, res[7:0]};
    endfunction

    task automatic apply(input int op, input int a, input int x, input int y,
                         input int b, input logic [3:0] f);
        logic [12:0] exp;
        @(posedge clk);
        op_i = op[4:0]; a_i = a[7:0]; x_i = x[7:0]; y_i = y[7:0];
        opnd_i = b[7:0]; flags_i = f;
        exp = model(op, a & 255, x & 255, y & 255, b & 255, f);
        @(negedge clk);
        n_vec++;
        if ({store_o, flags_o, result_o} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h x=%h y=%h b=%h f=%b: got st=%b f=%b r=%h, exp st=%b f=%b r=%h",
                     req_of(op), op, a_i, x_i, y_i, opnd_i, f,
                     store_o, flags_o, result_o, exp[12], exp[11:8], exp[7:0]);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int corner[4];
        corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80; corner[3] = 8'hFF;
        void'($urandom(32'h00C0FFEE));
        op_i = 0; a_i = 0; x_i = 0; y_i = 0; opnd_i = 0; flags_i = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // First vector after start: pass-through of zero sets Z (R10, R9)
        apply(16, 8'h12, 0, 0, 0, 4'b0000);

        // R1 / R2 / R3: boundary bytes against each other, both carries
        for (int op = 0; op <= 4; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int c = 0; c < 2; c++)
                        apply(op, corner[i], corner[j], corner[(i + j) % 4], corner[j], {3'b010, c[0]});

        // R1 overflow cases: 0x7F+1, 0x80+0xFF; R2: 0x80-1, 0x7F-0xFF
        apply(0, 8'h7F, 0, 0, 8'h01, 4'b0000);
        apply(0, 8'h80, 0, 0, 8'hFF, 4'b0000);
        apply(1, 8'h80, 0, 0, 8'h01, 4'b0001);
        apply(1, 8'h7F, 0, 0, 8'hFF, 4'b0001);

        // R5 / R6 / R8: every operand, both carries, V preset to catch changes
        for (int op = 9; op <= 14; op++)
            for (int b = 0; b < 256; b++)
                for (int c = 0; c < 2; c++)
                    apply(op, 8'h5A, 0, 0, b, {2'b01, c[0], c[0]});

        // R4: bit test masks, including zero-mask with sign bits set
        apply(8, 8'h0F, 0, 0, 8'hC0, 4'b0001);
        apply(8, 8'hFF, 0, 0, 8'h40, 4'b1000);
        apply(8, 8'h01, 0, 0, 8'h81, 4'b0110);

        // R7: AND-subtract equal (C=1,Z=1) and borrow cases
        apply(15, 8'hF3, 8'h3F, 0, 8'h33, 4'b0100);
        apply(15, 8'h0F, 8'hF0, 0, 8'h01, 4'b0101);

        // R11: undefined codes are inert
        for (int op = 17; op < 32; op++)
            apply(op, 8'hA5, 8'h3C, 8'hC3, 8'h99, 4'b1011);

        // Random mix over all codes (R1..R11)
        for (int k = 0; k < 40000; k++)
            apply(int'($urandom % 32), int'($urandom & 255), int'($urandom & 255),
                  int'($urandom & 255), int'($urandom & 255), 4'($urandom));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule